// File: doc/BRIEF.md
# Low-Power State Sequencer with Clock-Domain Gating

This block moves a processor between three power states under the control of external active-low stop-clock and sleep pins. In Normal every clock domain runs. In Stop-Grant the core clock is withheld, but the bus unit and interrupt controller keep running, so snoops and interrupts are still taken. In Sleep only the PLL stays enabled, and incoming snoop and interrupt strobes are dropped.

The block drives four enables: core, bus unit, interrupt controller and PLL. It also reports the current state as a two-bit code and passes on accept strobes for snoop and interrupt requests. The sleep and stop-clock pins are synchronized before use. Reset is asynchronous and overrides everything.

Top module: `lp_power_ctrl`

## Requirements
- R1: While `rst_n` is low, the state code reads 2'b00 (Normal), core, bus and interrupt clock enables are high, and both accept strobes are low. This takes effect without waiting for a clock edge.
- R2: In Normal, a low synchronized `stpclk_n` moves the state to 2'b01 (Stop-Grant). In Stop-Grant, `core_clk_en` is low and `bus_clk_en` and `intc_clk_en` are high.
- R3: In Stop-Grant, a high synchronized `stpclk_n` returns the state to Normal and raises `core_clk_en` again. This happens even when sleep is asserted in the same cycle.
- R4: In Stop-Grant with `stpclk_n` still low, a low synchronized `sleep_n` moves the state to 2'b10 (Sleep).
- R5: A low `sleep_n` while in Normal has no effect: the state stays 2'b00 and all enables stay high.
- R6: In Sleep, `core_clk_en`, `bus_clk_en` and `intc_clk_en` are low, and `pll_en` is high.
- R7: In Sleep, snoop and interrupt requests produce no accept strobe. Raising `stpclk_n` while `sleep_n` stays low leaves the state in Sleep.
- R8: In Sleep, a high synchronized `sleep_n` returns the state to Stop-Grant, which raises `bus_clk_en` and `intc_clk_en`.
- R9: In Normal and Stop-Grant, a request held high for one cycle gives an accept strobe exactly one clock later, lasting exactly one cycle.
- R10: A change on `stpclk_n` or `sleep_n` passes through two synchronizer flops. It reaches the state code on the third rising edge after the change, and not before. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stpclk_n | input | 1 | Active-low stop-clock request, asynchronous |
| sleep_n | input | 1 | Active-low sleep request, asynchronous |
| snoop_req | input | 1 | Snoop request strobe, synchronous |
| intr_req | input | 1 | Interrupt request strobe, synchronous |
| core_clk_en | output | 1 | Core clock domain enable |
| bus_clk_en | output | 1 | Bus unit clock domain enable |
| intc_clk_en | output | 1 | Interrupt controller clock domain enable |
| pll_en | output | 1 | PLL enable |
| pstate | output | 2 | State code: 00 Normal, 01 Stop-Grant, 10 Sleep |
| snoop_ack | output | 1 | Accepted snoop strobe |
| intr_ack | output | 1 | Accepted interrupt strobe |

## Verification
The bench builds the block with the default of two synchronizer stages, so every pin change lands on a known edge. This lets the bench confirm the exact three-edge latency. It also lets a stop-clock and sleep assertion made together be followed through Stop-Grant into Sleep inside a fixed settling window. With that fixed window, the sequence tests can reach priority cases on a known edge: a stop-clock release coinciding with sleep held low, and a stop-clock release made while already asleep.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_GRANT = 2'b01,
        ST_NAP   = 2'b10
    } pstate_e;

    typedef struct packed {
        pstate_e st;
        logic    snp_ack;
        logic    irq_ack;
    } seq_regs_t;

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= IDLE_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= async_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
    import lp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stop_act,
    input  logic    nap_act,
    input  logic    snoop_req,
    input  logic    intr_req,
    output pstate_e st_o,
    output logic    snp_ack_o,
    output logic    irq_ack_o
);
    seq_regs_t r_d, r_q;
    logic      awake;

    always_comb begin
        r_d   = r_q;
        awake = (r_q.st != ST_NAP);
        unique case (r_q.st)
            ST_RUN: begin
                if (stop_act) r_d.st = ST_GRANT;
            end
            ST_GRANT: begin
                if (!stop_act)    r_d.st = ST_RUN;
                else if (nap_act) r_d.st = ST_NAP;
            end
            ST_NAP: begin
                if (!nap_act) r_d.st = ST_GRANT;
            end
            default: r_d.st = ST_RUN;
        endcase
        r_d.snp_ack = snoop_req & awake;
        r_d.irq_ack = intr_req & awake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, snp_ack: 1'b0, irq_ack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st_o      = r_q.st;
    assign snp_ack_o = r_q.snp_ack;
    assign irq_ack_o = r_q.irq_ack;
endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
    import lp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stpclk_n,
    input  logic       sleep_n,
    input  logic       snoop_req,
    input  logic       intr_req,
    output logic       core_clk_en,
    output logic       bus_clk_en,
    output logic       intc_clk_en,
    output logic       pll_en,
    output logic [1:0] pstate,
    output logic       snoop_ack,
    output logic       intr_ack
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins_sync;
    pstate_e         cur_st;

    lp_sync #(
        .WIDTH   (NPIN),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL({NPIN{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({stpclk_n, sleep_n}),
        .sync_o (pins_sync)
    );

    lp_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_act (~pins_sync[1]),
        .nap_act  (~pins_sync[0]),
        .snoop_req(snoop_req),
        .intr_req (intr_req),
        .st_o     (cur_st),
        .snp_ack_o(snoop_ack),
        .irq_ack_o(intr_ack)
    );

    always_comb begin
        core_clk_en = (cur_st == ST_RUN);
        bus_clk_en  = (cur_st != ST_NAP);
        intc_clk_en = (cur_st != ST_NAP);
        pll_en      = 1'b1;
        pstate      = cur_st;
    end
endmodule

// File: rtl/lp_power_ctrl_chk.sv
module lp_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       core_clk_en,
    input logic       bus_clk_en,
    input logic       intc_clk_en,
    input logic       pll_en,
    input logic [1:0] pstate,
    input logic       snoop_ack,
    input logic       intr_ack
);
    a_r6_nap_gating: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b10) |-> (!core_clk_en && !bus_clk_en && !intc_clk_en && pll_en));

    a_r2_grant_gating: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b01) |-> (!core_clk_en && bus_clk_en && intc_clk_en));

    a_r4_nap_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b10 && $past(pstate) != 2'b10) |-> ($past(pstate) == 2'b01));

    a_r8_nap_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pstate) == 2'b10 && pstate != 2'b10) |-> (pstate == 2'b01));

    a_r7_no_ack_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == 2'b10) |=> (!snoop_ack && !intr_ack));

    a_r10_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        pstate != 2'b11);
endmodule

bind lp_power_ctrl lp_power_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_clk_en(core_clk_en),
    .bus_clk_en (bus_clk_en),
    .intc_clk_en(intc_clk_en),
    .pll_en     (pll_en),
    .pstate     (pstate),
    .snoop_ack  (snoop_ack),
    .intr_ack   (intr_ack)
);

// File: tb/sim_lp_power_ctrl.sv
`timescale 1ns/1ps
module sim_lp_power_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stpclk_n = 1'b1, sleep_n = 1'b1, snoop_req = 1'b0, intr_req = 1'b0;
    logic       core_clk_en, bus_clk_en, intc_clk_en, pll_en, snoop_ack, intr_ack;
    logic [1:0] pstate;
    int         n_chk = 0, n_bad = 0, cyc = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lp_power_ctrl u0 (.*);

    // {stpclk_n, sleep_n, expected state}
    localparam int NV = 13;
    localparam logic [3:0] VEC [NV] = '{
        {2'b11, 2'b00}, // R5 idle
        {2'b10, 2'b00}, // R5 sleep ignored in Normal
        {2'b00, 2'b10}, // R2 R4 both low -> via Stop-Grant into Sleep
        {2'b01, 2'b01}, // R8 sleep release
        {2'b00, 2'b10}, // R4
        {2'b10, 2'b10}, // R7 stop release ignored asleep
        {2'b11, 2'b00}, // R8 R3
        {2'b01, 2'b01}, // R2
        {2'b11, 2'b00}, // R3
        {2'b01, 2'b01}, // R2
        {2'b00, 2'b10}, // R4
        {2'b01, 2'b01}, // R8
        {2'b10, 2'b00}  // R3 stop release beats sleep, then R5
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input logic [1:0] st);
        check(req, pstate, st);
        check(req, {core_clk_en, pll_en}, {st == 2'b00, 1'b1});
        check(req, {bus_clk_en, intc_clk_en}, {2{st != 2'b10}});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        tick(2);
        check_outputs("R1 reset", 2'b00);
        check("R1 reset acks", {snoop_ack, intr_ack}, 2'b00);
        rst_n = 1'b1;
        tick(2);

        foreach (VEC[i]) begin
            stpclk_n = VEC[i][3];
            sleep_n  = VEC[i][2];
            tick(8);
            check_outputs($sformatf("R2-8 vector %0d", i), VEC[i][1:0]);
            snoop_req = 1'b1;
            intr_req  = 1'b1;
            tick(1);
            snoop_req = 1'b0;
            intr_req  = 1'b0;
            check($sformatf("R7 R9 ack vector %0d", i), {snoop_ack, intr_ack},
                  {2{VEC[i][1:0] != 2'b10}});
            tick(1);
            check("R9 ack one cycle", {snoop_ack, intr_ack}, 2'b00);
        end

        // R10: latency of three rising edges
        stpclk_n = 1'b1; sleep_n = 1'b1;
        tick(6);
        stpclk_n = 1'b0;
        tick(2);
        check("R10 not yet", pstate, 2'b00);
        tick(1);
        check("R10 third edge", pstate, 2'b01);

        // R9: single interrupt only
        intr_req = 1'b1;
        tick(1);
        intr_req = 1'b0;
        check("R9 intr only", {snoop_ack, intr_ack}, 2'b01);

        // R1: asynchronous reset from Sleep
        sleep_n = 1'b0;
        tick(6);
        check("R4 setup", pstate, 2'b10);
        #1 rst_n = 1'b0;
        #1;
        check_outputs("R1 async from Sleep", 2'b00);
        tick(2);
        check_outputs("R1 held", 2'b00);

        done = 1'b1;
        finish_run();
    end
endmodule